// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software from a free-running oscillator clock. One counter advances on every clock. When it reaches the interrupt timeout picked by a two-bit select field, the block raises an interrupt flag and starts a short, fixed reset-delay count. Software has two ways to stop the second stage before it ends: a restart strobe or a flag-clear strobe. If neither arrives, the block issues a one-clock system reset request and sets a sticky flag that records that a watchdog reset happened.

The timeout select sits in a small register inside the block. A write strobe loads it. Any reset event, asynchronous or raised by the watchdog, returns it to the shortest ratio. Writing the select during the first stage also restarts the count. The block has no data stream, so there is no valid/ready handshake. Every pin is a plain level or single-cycle strobe, sampled on the rising clock edge.

The exponent parameters scale every timeout. With the defaults, the interrupt timeouts are 2^12, 2^15, 2^18 and 2^21 cycles and the reset delay is 512 cycles.

Top module: `wdt_two_stage`

## Requirements
- R1: The interrupt timeout is 2^(BASE_EXP + 3*s) clock cycles, where s is the select value. Codes 0, 1, 2 and 3 give exponents BASE_EXP, +3, +6 and +9.
- R2: After the asynchronous reset, the select reads 0 and irq_flag_o, irq_o, rst_flag_o and rst_req_o are all low.
- R3: irq_flag_o rises on the T-th rising edge of counting, where T is the selected timeout. irq_o is high only while both the flag and irq_en_i are high.
- R4: With rst_en_i high, rst_req_o goes high on the 2^DLY_EXP-th rising edge after the edge that set the flag. It stays high for exactly one clock.
- R5: A restart strobe clears the timeout count in either stage and cancels a pending reset. It leaves irq_flag_o unchanged.
- R6: A flag-clear strobe clears irq_flag_o. If it arrives during the reset delay, it also cancels the reset and restarts the timeout count.
- R7: A select write during the first stage restarts the timeout count. A select write during the reset delay updates the select but does not move the reset.
- R8: rst_flag_o is set together with the reset request and stays set until a strobe on rflag_clr_i clears it.
- R9: When a watchdog reset is issued, the select returns to 0, irq_flag_o clears, and the timeout count restarts from zero on the same edge.
- R10: With rst_en_i low, the end of the reset delay produces no request and leaves rst_flag_o low. irq_flag_o stays set and counting resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running oscillator clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| sel_we_i | input | 1 | Strobe that loads sel_wdata_i into the select register |
| sel_wdata_i | input | 2 | New timeout select value |
| irq_en_i | input | 1 | Lets the flag drive irq_o |
| rst_en_i | input | 1 | Lets the end of the delay issue a reset request |
| kick_i | input | 1 | Restart strobe |
| flag_clr_i | input | 1 | Interrupt flag clear strobe |
| rflag_clr_i | input | 1 | Reset-occurred flag clear strobe |
| irq_flag_o | output | 1 | Interrupt timeout flag |
| irq_o | output | 1 | Interrupt request (flag gated by enable) |
| rst_flag_o | output | 1 | Sticky reset-occurred flag |
| rst_req_o | output | 1 | One-clock system reset request |
| sel_o | output | 2 | Current timeout select |

## Verification
Reset release and each strobe are counted as rising edge zero. irq_flag_o is due after exactly T more rising edges. rst_req_o is due 2^DLY_EXP edges after the edge that set the flag, and it falls one edge later. The select and the flags update on the edge of the strobe that changes them. The bench drives and samples on the falling edge. For each output it checks the sample one edge before the due edge, where the output must still be quiet, and the sample right after the due edge, where it must have changed. This exposes an off-by-one in either direction. Cancellation checks sample every cycle of a window that is longer than the delay.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    WD_COUNT = 1'b0,
    WD_DELAY = 1'b1
  } wd_state_e;

  localparam logic [1:0] WD_SEL_DEFAULT = 2'd0;
  localparam int unsigned WD_TAPS       = 4;
  localparam int unsigned WD_TAP_STEP   = 3;

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned BASE_EXP = 12,
  parameter int unsigned CNT_W    = BASE_EXP + 9
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output logic       hit_o
);
  import wdt_pkg::*;

  logic [CNT_W-1:0]   cnt_q;
  logic [WD_TAPS-1:0] tap_hit;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < WD_TAPS; g++) begin : g_tap
    localparam int unsigned TAP_EXP = BASE_EXP + WD_TAP_STEP * g;
    localparam logic [CNT_W-1:0] TAP_LAST = CNT_W'((64'd1 << TAP_EXP) - 64'd1);
    assign tap_hit[g] = (cnt_q == TAP_LAST);
  end

  assign hit_o = tap_hit[sel_i];

endmodule

// File: rtl/wdt_delay.sv
module wdt_delay #(
  parameter int unsigned DLY_EXP = 9
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);

  logic [DLY_EXP-1:0] dcnt_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      dcnt_q <= '0;
    end else if (clr_i) begin
      dcnt_q <= '0;
    end else if (en_i) begin
      dcnt_q <= dcnt_q + 1'b1;
    end
  end

  assign done_o = &dcnt_q;

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       hit_i,
  input  logic       dly_done_i,
  input  logic       kick_i,
  input  logic       flag_clr_i,
  input  logic       sel_we_i,
  input  logic [1:0] sel_wdata_i,
  input  logic       rst_en_i,
  input  logic       rflag_clr_i,
  output logic [1:0] sel_o,
  output logic       irq_flag_o,
  output logic       rst_flag_o,
  output logic       rst_req_o,
  output logic       main_clr_o,
  output logic       main_en_o,
  output logic       dly_clr_o,
  output logic       dly_en_o
);
  import wdt_pkg::*;

  wd_state_e  state_q, state_d;
  logic [1:0] sel_q, sel_d;
  logic       irq_flag_q, irq_flag_d;
  logic       rst_flag_q, rst_flag_d;
  logic       rst_req_q;

  logic in_cnt, in_dly;
  logic expire, abort, dly_end, fire;

  assign in_cnt  = (state_q == WD_COUNT);
  assign in_dly  = (state_q == WD_DELAY);
  assign expire  = in_cnt & hit_i & ~kick_i & ~sel_we_i;
  assign abort   = in_dly & (kick_i | flag_clr_i);
  assign dly_end = in_dly & ~abort & dly_done_i;
  assign fire    = dly_end & rst_en_i;

  assign main_clr_o = kick_i | (in_cnt & sel_we_i) | expire | abort | dly_end;
  assign main_en_o  = in_cnt;
  assign dly_clr_o  = ~in_dly | abort | dly_end;
  assign dly_en_o   = in_dly;

  always_comb begin
    state_d = state_q;
    if (expire) begin
      state_d = WD_DELAY;
    end else if (abort || dly_end) begin
      state_d = WD_COUNT;
    end
  end

  always_comb begin
    sel_d = sel_q;
    if (fire) begin
      sel_d = WD_SEL_DEFAULT;
    end else if (sel_we_i) begin
      sel_d = sel_wdata_i;
    end
  end

  always_comb begin
    irq_flag_d = irq_flag_q;
    if (fire) begin
      irq_flag_d = 1'b0;
    end else if (expire) begin
      irq_flag_d = 1'b1;
    end else if (flag_clr_i) begin
      irq_flag_d = 1'b0;
    end
  end

  always_comb begin
    rst_flag_d = rst_flag_q;
    if (fire) begin
      rst_flag_d = 1'b1;
    end else if (rflag_clr_i) begin
      rst_flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q    <= WD_COUNT;
      sel_q      <= WD_SEL_DEFAULT;
      irq_flag_q <= 1'b0;
      rst_flag_q <= 1'b0;
      rst_req_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      sel_q      <= sel_d;
      irq_flag_q <= irq_flag_d;
      rst_flag_q <= rst_flag_d;
      rst_req_q  <= fire;
    end
  end

  assign sel_o      = sel_q;
  assign irq_flag_o = irq_flag_q;
  assign rst_flag_o = rst_flag_q;
  assign rst_req_o  = rst_req_q;

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int unsigned BASE_EXP = 12,
  parameter int unsigned DLY_EXP  = 9
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       sel_we_i,
  input  logic [1:0] sel_wdata_i,
  input  logic       irq_en_i,
  input  logic       rst_en_i,
  input  logic       kick_i,
  input  logic       flag_clr_i,
  input  logic       rflag_clr_i,
  output logic       irq_flag_o,
  output logic       irq_o,
  output logic       rst_flag_o,
  output logic       rst_req_o,
  output logic [1:0] sel_o
);
  import wdt_pkg::*;

  localparam int unsigned CNT_W = BASE_EXP + WD_TAP_STEP * (WD_TAPS - 1);

  logic       hit;
  logic       dly_done;
  logic       main_clr, main_en;
  logic       dly_clr, dly_en;
  logic [1:0] sel_q;
  logic       flag_q;

  wdt_prescale #(
    .BASE_EXP (BASE_EXP),
    .CNT_W    (CNT_W)
  ) u_prescale (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .clr_i   (main_clr),
    .en_i    (main_en),
    .sel_i   (sel_q),
    .hit_o   (hit)
  );

  wdt_delay #(
    .DLY_EXP (DLY_EXP)
  ) u_delay (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .clr_i   (dly_clr),
    .en_i    (dly_en),
    .done_o  (dly_done)
  );

  wdt_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .hit_i       (hit),
    .dly_done_i  (dly_done),
    .kick_i      (kick_i),
    .flag_clr_i  (flag_clr_i),
    .sel_we_i    (sel_we_i),
    .sel_wdata_i (sel_wdata_i),
    .rst_en_i    (rst_en_i),
    .rflag_clr_i (rflag_clr_i),
    .sel_o       (sel_q),
    .irq_flag_o  (flag_q),
    .rst_flag_o  (rst_flag_o),
    .rst_req_o   (rst_req_o),
    .main_clr_o  (main_clr),
    .main_en_o   (main_en),
    .dly_clr_o   (dly_clr),
    .dly_en_o    (dly_en)
  );

  assign sel_o      = sel_q;
  assign irq_flag_o = flag_q;
  assign irq_o      = flag_q & irq_en_i;

endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk (
  input logic       clk_i,
  input logic       rst_n_i,
  input logic       rst_en_i,
  input logic       kick_i,
  input logic       rflag_clr_i,
  input logic       irq_flag_o,
  input logic       rst_flag_o,
  input logic       rst_req_o,
  input logic [1:0] sel_o
);

  assert_req_single_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rst_req_o |=> !rst_req_o);

  assert_req_after_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rst_req_o |-> $past(irq_flag_o));

  assert_kick_blocks_req_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    kick_i |=> !rst_req_o);

  assert_flag_with_req_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rst_req_o |-> rst_flag_o);

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rst_flag_o && !rflag_clr_i) |=> rst_flag_o);

  assert_default_after_req_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rst_req_o |-> (sel_o == 2'd0 && !irq_flag_o));

  assert_req_needs_enable_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rst_req_o |-> $past(rst_en_i));

endmodule

bind wdt_two_stage wdt_two_stage_chk chk_i (
  .clk_i       (clk_i),
  .rst_n_i     (rst_n_i),
  .rst_en_i    (rst_en_i),
  .kick_i      (kick_i),
  .rflag_clr_i (rflag_clr_i),
  .irq_flag_o  (irq_flag_o),
  .rst_flag_o  (rst_flag_o),
  .rst_req_o   (rst_req_o),
  .sel_o       (sel_o)
);

// File: tb/wdt_two_stage_tb_top.sv
module wdt_two_stage_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 4;
  localparam int DEXP       = 5;
  localparam int T0         = 1 << BASE;
  localparam int D          = 1 << DEXP;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel_we, irq_en, rst_en, kick, flag_clr, rflag_clr;
  logic [1:0] sel_wdata;
  logic       irq_flag, irq, rst_flag, rst_req;
  logic [1:0] sel;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdt_two_stage #(.BASE_EXP(BASE), .DLY_EXP(DEXP)) dut_i (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .sel_we_i    (sel_we),
    .sel_wdata_i (sel_wdata),
    .irq_en_i    (irq_en),
    .rst_en_i    (rst_en),
    .kick_i      (kick),
    .flag_clr_i  (flag_clr),
    .rflag_clr_i (rflag_clr),
    .irq_flag_o  (irq_flag),
    .irq_o       (irq),
    .rst_flag_o  (rst_flag),
    .rst_req_o   (rst_req),
    .sel_o       (sel)
  );

  function automatic int tmo(input int s);
    return 1 << (BASE + 3 * s);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    sel_we = 0; sel_wdata = 0; irq_en = 0; rst_en = 0;
    kick = 0; flag_clr = 0; rflag_clr = 0;
    rst_n = 0;
    step(2);
    rst_n = 1;
  endtask

  task automatic pulse_kick();
    kick = 1; step(1); kick = 0;
  endtask

  task automatic pulse_flag_clr();
    flag_clr = 1; step(1); flag_clr = 0;
  endtask

  task automatic pulse_rflag_clr();
    rflag_clr = 1; step(1); rflag_clr = 0;
  endtask

  task automatic write_sel(input logic [1:0] v);
    sel_we = 1; sel_wdata = v; step(1); sel_we = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R2", "irq_flag", irq_flag, 0);
    chk("R2", "irq", irq, 0);
    chk("R2", "rst_flag", rst_flag, 0);
    chk("R2", "rst_req", rst_req, 0);
    chk("R2", "sel", sel, 0);
  endtask

  task automatic t_default_cycle();
    do_reset();
    irq_en = 1; rst_en = 1;
    step(T0 - 1);
    chk("R1", "flag before default timeout", irq_flag, 0);
    step(1);
    chk("R3", "flag at default timeout", irq_flag, 1);
    chk("R3", "irq enabled", irq, 1);
    irq_en = 0; #1;
    chk("R3", "irq masked", irq, 0);
    irq_en = 1;
    step(D - 1);
    chk("R4", "req one edge early", rst_req, 0);
    step(1);
    chk("R4", "req due", rst_req, 1);
    chk("R8", "rst_flag set", rst_flag, 1);
    chk("R9", "flag cleared by reset", irq_flag, 0);
    chk("R9", "sel default", sel, 0);
    step(1);
    chk("R4", "req one clock only", rst_req, 0);
    chk("R8", "rst_flag holds", rst_flag, 1);
    step(T0 - 2);
    chk("R9", "count restarted, flag early", irq_flag, 0);
    step(1);
    chk("R9", "count restarted, flag due", irq_flag, 1);
    pulse_rflag_clr();
    chk("R8", "rst_flag cleared", rst_flag, 0);
  endtask

  task automatic t_select();
    do_reset();
    irq_en = 1; rst_en = 1;
    for (int s = 1; s < 4; s++) begin
      write_sel(2'(s));
      chk("R1", "sel loaded", sel, s);
      step(tmo(s) - 1);
      chk("R1", "flag before timeout", irq_flag, 0);
      step(1);
      chk("R1", "flag at timeout", irq_flag, 1);
      pulse_flag_clr();
      chk("R6", "flag cleared in delay", irq_flag, 0);
    end
  endtask

  task automatic t_restart();
    int seen;
    do_reset();
    rst_en = 1;
    step(10);
    pulse_kick();
    step(T0 - 1);
    chk("R5", "flag delayed by restart", irq_flag, 0);
    step(1);
    chk("R5", "flag after restart", irq_flag, 1);
    step(20);
    pulse_kick();
    chk("R5", "restart keeps flag", irq_flag, 1);
    seen = 0;
    for (int i = 0; i < D + 8; i++) begin
      step(1);
      if (rst_req) seen++;
    end
    chk("R5", "requests after restart in delay", seen, 0);
    chk("R5", "rst_flag after cancel", rst_flag, 0);
  endtask

  task automatic t_clear();
    int seen;
    do_reset();
    rst_en = 1;
    step(T0);
    chk("R6", "flag set", irq_flag, 1);
    step(5);
    pulse_flag_clr();
    chk("R6", "flag cleared", irq_flag, 0);
    seen = 0;
    for (int i = 0; i < T0 - 1; i++) begin
      step(1);
      if (rst_req || irq_flag) seen++;
    end
    chk("R6", "quiet after clear", seen, 0);
    step(1);
    chk("R6", "count restarted by clear", irq_flag, 1);
  endtask

  task automatic t_selwrite();
    do_reset();
    rst_en = 1;
    step(10);
    write_sel(2'd0);
    step(T0 - 1);
    chk("R7", "write restarted count", irq_flag, 0);
    step(1);
    chk("R7", "flag after rewrite", irq_flag, 1);
    step(5);
    write_sel(2'd1);
    chk("R7", "sel updated in delay", sel, 1);
    step(D - 7);
    chk("R7", "req not yet", rst_req, 0);
    step(1);
    chk("R7", "req not moved by write", rst_req, 1);
    chk("R9", "sel back to default", sel, 0);
  endtask

  task automatic t_no_reset_en();
    int seen;
    do_reset();
    rst_en = 0;
    step(T0);
    chk("R10", "flag set", irq_flag, 1);
    seen = 0;
    for (int i = 0; i < 2 * D + 10; i++) begin
      step(1);
      if (rst_req) seen++;
    end
    chk("R10", "no request", seen, 0);
    chk("R10", "rst_flag stays low", rst_flag, 0);
    chk("R10", "flag stays set", irq_flag, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    @(negedge clk);
    t_reset_state();
    t_default_cycle();
    t_select();
    t_restart();
    t_clear();
    t_selwrite();
    t_no_reset_en();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule